// File: doc/BRIEF.md
# Radix-16 Booth Multiplier with Redundant Odd Multiples

This block multiplies two 16-bit two's complement operands and returns the exact 32-bit signed product. The second operand is recoded into four radix-16 digits, each lying between −8 and +8. Each digit selects the multiplicand scaled by its magnitude and applies its sign.

Only the shift-only multiples 0, X, 2X, 4X and 8X are ever formed. A magnitude that is not a power of two is expressed as a pair of those multiples. The pairs are 3 = 4 − 1, 5 = 4 + 1, 6 = 8 − 2 and 7 = 8 − 1. Both members of the pair go straight into the carry-save tree, so no adder builds an odd multiple ahead of time.

Negation is done by inverting the row. The missing +1 of every negated row is gathered into one correction word with no carries. That word is absorbed by a 3:2 stage together with the first two rows. A level of 4:2 compressors then leaves four rows, which are registered.

The pipeline has three register stages: recode and first reduction, second 4:2 reduction, and the final carry-propagate add. It accepts one operand pair per cycle and never stalls.

Top module: `rbm_mul16`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted pair has travelled through the pipeline, `out_valid` is low.
- R2: A pair accepted with `in_valid` high at a clock edge gives `out_valid` high exactly three rising edges later. `out_valid` is never high without such an accepted pair.
- R3: When `out_valid` is high, `out_prod` equals the two's complement product of `in_a` (the multiplicand) and `in_b` (the recoded operand), both signed, as a 32-bit signed value.
- R4: The extreme operands give exact products, for example −32768 × −32768 = 0x4000_0000 and −32768 × 32767 = 0xC000_8000.
- R5: Pairs presented on consecutive cycles produce results on consecutive cycles, in the same order, with no gap and no stall.
- R6: While `out_valid` is low, `out_prod` keeps the value of the last result.
- R7: `in_b` is recoded into four digits. Digit k is taken from the window b[4k+3..4k−1], with b[−1] = 0, and has the value −8·b[4k+3] + 4·b[4k+2] + 2·b[4k+1] + b[4k] + b[4k−1]. The sum of digit k × 16^k over all four digits equals `in_b`, and every nibble pattern in every digit position yields a correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 16 | Signed multiplicand |
| in_b | input | 16 | Signed multiplier, Booth recoded |
| out_valid | output | 1 | Product present this cycle |
| out_prod | output | 32 | Signed product |

## Verification
On every cycle, the bound checker compares each result with a delayed signed product, and it ties every `out_valid` to an accepted pair three cycles earlier in both directions. It also confirms that the four decoded digits recombine to `in_b` and that the result holds while no result is presented.

Some behaviours can only be shown by the bench's scenarios:
- the specific extreme products;
- every nibble pattern in every digit position;
- continuous back-to-back bursts mixed with idle gaps;
- the idle output during and just after reset.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  // Shift-only multiple of the multiplicand selected by a digit term
  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_X1   = 3'd1,
    SEL_X2   = 3'd2,
    SEL_X4   = 3'd3,
    SEL_X8   = 3'd4
  } mult_sel_e;

  // One decoded radix-16 digit: value = (neg ? -1 : 1) * (hi +/- lo)
  typedef struct packed {
    logic      neg;
    logic [3:0] mag;
    mult_sel_e sel_hi;
    mult_sel_e sel_lo;
    logic      lo_sub;
  } digit_t;

endpackage

// File: rtl/rbm_digit_dec.sv
module rbm_digit_dec
  import rbm_pkg::*;
(
  input  logic [4:0] win,
  output digit_t     dig
);
  logic [3:0] low_sum;
  logic [3:0] mag;

  always_comb begin
    low_sum = {1'b0, win[3:1]} + {3'b000, win[0]};
    mag     = win[4] ? (4'd8 - low_sum) : low_sum;

    dig.neg    = win[4] && (low_sum != 4'd8);
    dig.mag    = mag;
    dig.sel_hi = SEL_ZERO;
    dig.sel_lo = SEL_ZERO;
    dig.lo_sub = 1'b0;

    unique case (mag)
      4'd1: dig.sel_hi = SEL_X1;
      4'd2: dig.sel_hi = SEL_X2;
      4'd3: begin dig.sel_hi = SEL_X4; dig.sel_lo = SEL_X1; dig.lo_sub = 1'b1; end
      4'd4: dig.sel_hi = SEL_X4;
      4'd5: begin dig.sel_hi = SEL_X4; dig.sel_lo = SEL_X1; end
      4'd6: begin dig.sel_hi = SEL_X8; dig.sel_lo = SEL_X2; dig.lo_sub = 1'b1; end
      4'd7: begin dig.sel_hi = SEL_X8; dig.sel_lo = SEL_X1; dig.lo_sub = 1'b1; end
      4'd8: dig.sel_hi = SEL_X8;
      default: ;
    endcase
  end
endmodule

// File: rtl/rbm_row_gen.sv
module rbm_row_gen
  import rbm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SHIFT = 0,
  localparam int PW   = 2 * DW
) (
  input  logic [DW-1:0] x,
  input  digit_t        dig,
  output logic [PW-1:0] row_hi,
  output logic [PW-1:0] row_lo,
  output logic [1:0]    corr
);
  logic [PW-1:0] xe;
  logic [PW-1:0] m_hi, m_lo;
  logic          neg_hi, neg_lo;

  function automatic logic [PW-1:0] scale(input logic [PW-1:0] v, input mult_sel_e s);
    case (s)
      SEL_X1:  return v;
      SEL_X2:  return v << 1;
      SEL_X4:  return v << 2;
      SEL_X8:  return v << 3;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    xe     = {{DW{x[DW-1]}}, x};
    m_hi   = scale(xe, dig.sel_hi);
    m_lo   = scale(xe, dig.sel_lo);
    neg_hi = dig.neg && (dig.sel_hi != SEL_ZERO);
    neg_lo = (dig.neg ^ dig.lo_sub) && (dig.sel_lo != SEL_ZERO);
    // invert before shifting: the +1 lands at bit SHIFT, kept in corr
    row_hi = (neg_hi ? ~m_hi : m_hi) << SHIFT;
    row_lo = (neg_lo ? ~m_lo : m_lo) << SHIFT;
    corr   = {1'b0, neg_hi} + {1'b0, neg_lo};
  end
endmodule

// File: rtl/rbm_csa32.sv
module rbm_csa32 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  logic [W-1:0] maj;

  always_comb begin
    s   = a ^ b ^ c;
    maj = (a & b) | (a & c) | (b & c);
    cy  = {maj[W-2:0], 1'b0};
  end
endmodule

// File: rtl/rbm_csa42.sv
module rbm_csa42 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  logic [W-1:0] s0, c0;

  rbm_csa32 #(.W(W)) u_lvl0 (.a(a),  .b(b),  .c(c), .s(s0), .cy(c0));
  rbm_csa32 #(.W(W)) u_lvl1 (.a(s0), .b(c0), .c(d), .s(s),  .cy(cy));
endmodule

// File: rtl/rbm_mul16.sv
module rbm_mul16
  import rbm_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW   = 2 * DW,
  localparam int NDIG = DW / 4,
  localparam int NROW = 2 * NDIG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  output logic [PW-1:0] out_prod
);
  // The reduction tree below is laid out for four digits (DW = 16).

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // ---------------- stage 1: recode, select, first reduction ----------
  logic [DW:0]              b_ext;
  digit_t [NDIG-1:0]        dig;
  logic [NROW-1:0][PW-1:0]  rows;
  logic [NDIG-1:0][1:0]     corr;
  logic [PW-1:0]            corr_word;

  assign b_ext = {in_b, 1'b0};

  for (genvar k = 0; k < NDIG; k++) begin : g_digit
    rbm_digit_dec u_dec (
      .win (b_ext[4*k +: 5]),
      .dig (dig[k])
    );
    rbm_row_gen #(.DW(DW), .SHIFT(4*k)) u_row (
      .x      (in_a),
      .dig    (dig[k]),
      .row_hi (rows[2*k]),
      .row_lo (rows[2*k+1]),
      .corr   (corr[k])
    );
  end

  always_comb begin
    corr_word = '0;
    for (int k = 0; k < NDIG; k++) corr_word[4*k +: 2] = corr[k];
  end

  logic [PW-1:0]         t_s, t_c;
  logic [3:0][PW-1:0]    s1_n, s1_q;

  rbm_csa32 #(.W(PW)) u_corr_fold (
    .a(rows[0]), .b(rows[1]), .c(corr_word), .s(t_s), .cy(t_c)
  );
  rbm_csa42 #(.W(PW)) u_c42_lo (
    .a(t_s), .b(t_c), .c(rows[2]), .d(rows[3]), .s(s1_n[0]), .cy(s1_n[1])
  );
  rbm_csa42 #(.W(PW)) u_c42_hi (
    .a(rows[4]), .b(rows[5]), .c(rows[6]), .d(rows[7]), .s(s1_n[2]), .cy(s1_n[3])
  );

  // ---------------- stage 2: four rows to two --------------------------
  logic [1:0][PW-1:0] s2_n, s2_q;

  rbm_csa42 #(.W(PW)) u_c42_fin (
    .a(s1_q[0]), .b(s1_q[1]), .c(s1_q[2]), .d(s1_q[3]), .s(s2_n[0]), .cy(s2_n[1])
  );

  // ---------------- stage 3: carry-propagate add -----------------------
  logic [PW-1:0] sum_n;
  logic [2:0]    vld_n, vld_q;

  always_comb begin
    sum_n = s2_q[0] + s2_q[1];
    vld_n = {vld_q[1:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (in_valid) s1_q <= s1_n;
  end

  always_ff @(posedge clk) begin
    if (vld_q[0]) s2_q <= s2_n;
  end

  always_ff @(posedge clk) begin
    if (vld_q[1]) out_prod <= sum_n;
  end

  assign out_valid = vld_q[2];
endmodule

// File: rtl/rbm_mul16_chk.sv
module rbm_mul16_chk
  import rbm_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW   = 2 * DW,
  localparam int NDIG = DW / 4
) (
  input logic              clk,
  input logic              rst_q,
  input logic              in_valid,
  input logic [DW-1:0]     in_a,
  input logic [DW-1:0]     in_b,
  input logic              out_valid,
  input logic [PW-1:0]     out_prod,
  input digit_t [NDIG-1:0] dig
);
  logic signed [PW-1:0] ref_prod;
  logic signed [PW-1:0] rec_sum;

  always_comb begin
    ref_prod = PW'($signed(in_a)) * PW'($signed(in_b));
    rec_sum  = '0;
    for (int k = 0; k < NDIG; k++) begin
      if (dig[k].neg) rec_sum = rec_sum - (PW'(dig[k].mag) << (4*k));
      else            rec_sum = rec_sum + (PW'(dig[k].mag) << (4*k));
    end
  end

  // R2: each accepted pair leads to a result three edges later
  p_latency_fwd_r2: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |-> ##3 out_valid);

  // R2: no result without an accepted pair three edges earlier
  p_latency_bwd_r2: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(in_valid, 3));

  // R3: product matches signed reference
  p_product_r3: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (out_prod == $past(ref_prod, 3)));

  // R6: output holds between results
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !out_valid |-> $stable(out_prod));

  // R7: decoded digits recombine to the multiplier
  p_recode_sum_r7: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |-> (rec_sum == PW'($signed(in_b))));
endmodule

bind rbm_mul16 rbm_mul16_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .dig       (dig)
);

// File: tb/rbm_mul16_bench.sv
`timescale 1ns/1ps
module rbm_mul16_bench;
  localparam int DW = 16;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          out_valid;
  logic [PW-1:0] out_prod;

  always #4 clk = ~clk;   // 125 MHz

  rbm_mul16 #(.DW(DW)) u_rbm_mul16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
  );

  typedef struct {
    logic [PW-1:0] exp;
    int            due;
    string         tag;
  } item_t;

  item_t queue_q[$];
  int    checks = 0;
  int    fails  = 0;
  int    tick   = 0;
  logic  have_last = 1'b0;
  logic [PW-1:0] last_prod;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag);
    item_t it;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_a     = a;
    in_b     = b;
    it.exp   = PW'($signed(a)) * PW'($signed(b));
    it.due   = tick + 4;
    it.tag   = tag;
    queue_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      tick++;
      if (!rst_n) begin
        check(out_valid == 1'b0, "R1 out_valid in reset", PW'(out_valid), '0);
      end else if (out_valid) begin
        if (queue_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", out_prod, '0);
        end else begin
          item_t it;
          it = queue_q.pop_front();
          check(out_prod == it.exp, it.tag, out_prod, it.exp);
          check(tick == it.due, "R2 latency", PW'(tick), PW'(it.due));
        end
        last_prod = out_prod;
        have_last = 1'b1;
      end else if (have_last) begin
        check(out_prod == last_prod, "R6 hold while idle", out_prod, last_prod);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", queue_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] corners [6];
    corners = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001, 16'hFFF8};

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: nothing emerges right after release
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle after release", PW'(out_valid), '0);
    end

    // R4: extreme operands, spaced out
    drive(16'h8000, 16'h8000, "R4 min*min");
    idle(4);
    drive(16'h8000, 16'h7FFF, "R4 min*max");
    idle(4);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        drive(corners[i], corners[j], "R4 corner pair");
    idle(5);

    // R7: every nibble in every digit position
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 16; n++) begin
        drive(16'd12345, DW'(n) << (4*k), "R7 digit sweep");
        drive(16'hB6C3, (DW'(n) << (4*k)) | 16'h0008, "R7 digit sweep neighbour");
      end
    idle(5);

    // R5: long back-to-back burst
    for (int i = 0; i < 2000; i++)
      drive(DW'($urandom), DW'($urandom), "R5 back-to-back");
    idle(5);

    // R3: random pairs with random gaps
    for (int i = 0; i < 10000; i++) begin
      drive(DW'($urandom), DW'($urandom), "R3 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(8);
    @(negedge clk);
    check(queue_q.size() == 0, "R2 all results drained", PW'(queue_q.size()), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule